// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block collects sixteen device interrupt lines and presents them to a processor as one interrupt output. It is built from two eight-line priority stages. The upper stage, the "primary" stage, takes device lines 0 to 7. The lower stage takes device lines 8 to 15, and its combined request occupies slot 2 of the primary stage. Device input 2 is therefore not used. Because of this slot insertion, the overall priority order is not linear in the line number. Each device input passes through a synchronizer. A rising edge on the input latches a pending request.

The processor acknowledges the interrupt with a one-cycle pulse. The block answers with an 8-bit vector number and marks the chosen line as being in service. A line in service holds back every line of equal or lower priority until software issues a non-specific end-of-interrupt pulse. Software controls a 16-bit mask through a simple write port.

Top module: `pic_cascade_top`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are low, nothing is pending or in service, and the mask is all zeros (every line enabled).
- R2: A request is latched on a rising edge of its `irq_in` bit. `int_out` rises on the third clock edge after the input goes high. A line held high after being serviced does not request again.
- R3: `irq_in[2]` has no effect. It never causes `int_out` or a vector.
- R4: Priority from highest to lowest is line 0, line 1, lines 8 to 15 in ascending order, then lines 3 to 7 in ascending order.
- R5: A serviced line n in 0..7 returns vector 0x08 + n.
- R6: A serviced line n in 8..15 returns vector 0x70 + (n - 8).
- R7: An `inta` pulse gives `vec_valid` high for exactly the next cycle, with `vec_out` holding the vector. The serviced line moves from pending to in service.
- R8: `int_out` is high only when a pending, unmasked request has strictly higher priority than every line in service. Lower requests stay pending and are forwarded once the blocking lines receive EOI.
- R9: A higher-priority request that arrives while a lower line is in service raises `int_out`. This includes one lower-stage line preempting another lower-stage line.
- R10: Mask bit n set (1 = blocked) stops line n from being forwarded, but the request stays latched and is forwarded once the bit is cleared. Mask bit 2 blocks all of lines 8 to 15.
- R11: An `eoi` pulse clears the highest-priority in-service line. For a lower-stage line, the primary stage's slot-2 in-service bit is cleared once no lower-stage line remains in service.
- R12: An `inta` pulse while `int_out` is low returns the spurious vector 0x0F and changes no pending or in-service state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Asynchronous device request lines; bit 2 unused |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 16 | New mask value, 1 blocks a line |
| inta | input | 1 | One-cycle interrupt acknowledge from the processor |
| eoi | input | 1 | One-cycle non-specific end-of-interrupt |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector number of the last acknowledge |
| vec_valid | output | 1 | High for one cycle after `inta` |

## Verification
The bench targets the places where the priority order breaks from line order:
- Two lower-stage lines raised in the same cycle.
- A lower-stage line competing against line 3.
- Line 1 preempting an in-service lower-stage line.
- Line 8 preempting line 9.

A design that ranked by raw line number would pick line 3 over line 15. A design that blocked on the whole slot-2 in-service bit would never let line 8 preempt line 9.

The EOI sequence with two nested lower-stage lines catches a design that clears the slot-2 bit too early or too late. Clearing it too early would let line 12 fire while line 9 is still in service. Clearing it too late would leave line 12 stuck.

Further checks cover:
- Masking slot 2 while line 4 still gets through.
- A spurious acknowledge issued while line 1 waits behind line 0.
- A request held high, which a level-sensitive design would fire again.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int STAGE_LINES = 8;
    localparam int STAGE_IW    = $clog2(STAGE_LINES);
    localparam int TOTAL_LINES = 2 * STAGE_LINES;
    localparam int VEC_W       = 8;

    typedef struct packed {
        logic [TOTAL_LINES-1:0] pend;
        logic [STAGE_LINES-1:0] svc_pri;
        logic [STAGE_LINES-1:0] svc_sec;
        logic [TOTAL_LINES-1:0] mask;
        logic [VEC_W-1:0]       vec;
        logic                   vec_valid;
    } pic_state_t;
endpackage

// File: rtl/pic_edge_capture.sv
module pic_edge_capture #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] sync_q [STAGES];
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) sync_q[k] <= '0;
            last_q <= '0;
        end else begin
            sync_q[0] <= async_in;
            for (int k = 1; k < STAGES; k++) sync_q[k] <= sync_q[k-1];
            last_q <= sync_q[STAGES-1];
        end
    end

    // one-cycle pulse on a low-to-high transition of the synchronized line
    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pic_prio_stage.sv
module pic_prio_stage #(
    parameter int N        = 8,
    parameter bit CASC_EN  = 1'b0,
    parameter int CASC_IDX = 2,
    localparam int IW      = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  svc,
    output logic          req_valid,
    output logic [IW-1:0] req_idx,
    output logic          svc_valid,
    output logic [IW-1:0] svc_idx,
    output logic          fire
);
    logic equal_ok;

    // lowest index wins in both scans
    always_comb begin
        req_valid = 1'b0;
        req_idx   = '0;
        svc_valid = 1'b0;
        svc_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                req_valid = 1'b1;
                req_idx   = IW'(i);
            end
            if (svc[i]) begin
                svc_valid = 1'b1;
                svc_idx   = IW'(i);
            end
        end
    end

    // the cascade slot may pass an equal in-service slot: the lower stage
    // has already compared against its own in-service lines
    generate
        if (CASC_EN) begin : g_casc
            assign equal_ok = (req_idx == IW'(CASC_IDX)) && (svc_idx == req_idx);
        end else begin : g_plain
            assign equal_ok = 1'b0;
        end
    endgenerate

    assign fire = req_valid && (!svc_valid || (svc_idx > req_idx) || equal_ok);
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top
    import pic_pkg::*;
#(
    parameter int          CASCADE_LINE = 2,
    parameter int          SYNC_STAGES  = 2,
    parameter logic [7:0]  PRI_BASE     = 8'h08,
    parameter logic [7:0]  SEC_BASE     = 8'h70
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] irq_in,
    input  logic        mask_wr,
    input  logic [15:0] mask_wdata,
    input  logic        inta,
    input  logic        eoi,
    output logic        int_out,
    output logic [7:0]  vec_out,
    output logic        vec_valid
);
    localparam logic [STAGE_IW-1:0]    CASC_I    = STAGE_IW'(CASCADE_LINE);
    localparam logic [TOTAL_LINES-1:0] CASC_BIT  = TOTAL_LINES'(1) << CASCADE_LINE;
    localparam logic [VEC_W-1:0]       SPURIOUS  = PRI_BASE + VEC_W'(STAGE_LINES - 1);

    pic_state_t q, d;

    logic [TOTAL_LINES-1:0] rise;
    logic [STAGE_LINES-1:0] pri_req, sec_req;
    logic                   pri_rv, pri_sv, pri_fire;
    logic                   sec_rv, sec_sv, sec_fire;
    logic [STAGE_IW-1:0]    pri_ri, pri_si, sec_ri, sec_si;

    pic_edge_capture #(.WIDTH(TOTAL_LINES), .STAGES(SYNC_STAGES)) u_capture (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .rise(rise)
    );

    assign sec_req = q.pend[TOTAL_LINES-1:STAGE_LINES] & ~q.mask[TOTAL_LINES-1:STAGE_LINES];

    pic_prio_stage #(.N(STAGE_LINES), .CASC_EN(1'b0), .CASC_IDX(CASCADE_LINE)) u_sec (
        .req(sec_req), .svc(q.svc_sec),
        .req_valid(sec_rv), .req_idx(sec_ri),
        .svc_valid(sec_sv), .svc_idx(sec_si), .fire(sec_fire)
    );

    always_comb begin
        pri_req               = q.pend[STAGE_LINES-1:0];
        pri_req[CASCADE_LINE] = sec_fire;
        pri_req               = pri_req & ~q.mask[STAGE_LINES-1:0];
    end

    pic_prio_stage #(.N(STAGE_LINES), .CASC_EN(1'b1), .CASC_IDX(CASCADE_LINE)) u_pri (
        .req(pri_req), .svc(q.svc_pri),
        .req_valid(pri_rv), .req_idx(pri_ri),
        .svc_valid(pri_sv), .svc_idx(pri_si), .fire(pri_fire)
    );

    always_comb begin
        d           = q;
        d.vec_valid = 1'b0;

        if (mask_wr) d.mask = mask_wdata;

        // non-specific end of interrupt: drop the top in-service line
        if (eoi && pri_sv) begin
            if (pri_si == CASC_I) begin
                if (sec_sv) begin
                    d.svc_sec[sec_si] = 1'b0;
                    if ((q.svc_sec & ~(STAGE_LINES'(1) << sec_si)) == '0)
                        d.svc_pri[CASCADE_LINE] = 1'b0;
                end else begin
                    d.svc_pri[CASCADE_LINE] = 1'b0;
                end
            end else begin
                d.svc_pri[pri_si] = 1'b0;
            end
        end

        // acknowledge: return a vector and move the winner into service
        if (inta) begin
            d.vec_valid = 1'b1;
            if (pri_fire) begin
                if (pri_ri == CASC_I) begin
                    d.vec                    = SEC_BASE + VEC_W'(sec_ri);
                    d.svc_sec[sec_ri]        = 1'b1;
                    d.svc_pri[CASCADE_LINE]  = 1'b1;
                    d.pend[{1'b1, sec_ri}]   = 1'b0;
                end else begin
                    d.vec                    = PRI_BASE + VEC_W'(pri_ri);
                    d.svc_pri[pri_ri]        = 1'b1;
                    d.pend[{1'b0, pri_ri}]   = 1'b0;
                end
            end else begin
                d.vec = SPURIOUS;
            end
        end

        // new edges are latched last so they are never lost to a clear
        d.pend = d.pend | (rise & ~CASC_BIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign int_out   = pri_fire;
    assign vec_out   = q.vec;
    assign vec_valid = q.vec_valid;

    assert_int_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((q.pend & ~q.mask) != '0));

    assert_ack_gives_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> vec_valid);

    assert_ack_marks_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out) |=> (q.svc_pri != '0));

    assert_cascade_slot_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.svc_sec != '0) == q.svc_pri[CASCADE_LINE]);

    assert_spurious_vector_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_out) |=> (vec_out == SPURIOUS));

    assert_cascade_input_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pend[CASCADE_LINE]);

    assert_mask_blocks_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.mask[CASCADE_LINE] |-> !(int_out && pri_ri == CASC_I));
endmodule

// File: tb/pic_cascade_top_test.sv
module pic_cascade_top_test;
    localparam time PERIOD = 20ns;

    localparam logic [1:0] OP_REQ = 2'd0, OP_ACK = 2'd1, OP_EOI = 2'd2, OP_MSK = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] arg;
        logic        exp_int;
        logic [7:0]  exp_vec;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 46;
    localparam row_t ROWS [NROWS] = '{
        '{OP_REQ, 16'h0020, 1'b1, 8'h00, 4'd2},   // R2 line 5 latched
        '{OP_ACK, 16'h0000, 1'b0, 8'h0D, 4'd5},   // R5 R7
        '{OP_REQ, 16'h0008, 1'b1, 8'h00, 4'd9},   // R9 line 3 over 5
        '{OP_ACK, 16'h0000, 1'b0, 8'h0B, 4'd5},   // R5
        '{OP_REQ, 16'h0080, 1'b0, 8'h00, 4'd8},   // R8 line 7 held
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd11},  // R11 clears 3 only
        '{OP_EOI, 16'h0000, 1'b1, 8'h00, 4'd8},   // R8 line 7 forwarded
        '{OP_ACK, 16'h0000, 1'b0, 8'h0F, 4'd5},   // R5 line 7
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd11},  // R11
        '{OP_REQ, 16'h1200, 1'b1, 8'h00, 4'd6},   // R6 lines 9 and 12
        '{OP_ACK, 16'h0000, 1'b0, 8'h71, 4'd4},   // R4 line 9 first
        '{OP_REQ, 16'h0002, 1'b1, 8'h00, 4'd9},   // R9 line 1 over slot
        '{OP_ACK, 16'h0000, 1'b0, 8'h09, 4'd5},   // R5
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd11},  // R11 clears 1
        '{OP_REQ, 16'h0100, 1'b1, 8'h00, 4'd9},   // R9 line 8 over 9
        '{OP_ACK, 16'h0000, 1'b0, 8'h70, 4'd6},   // R6
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd11},  // R11 slot still busy
        '{OP_EOI, 16'h0000, 1'b1, 8'h00, 4'd11},  // R11 slot freed, 12 fires
        '{OP_ACK, 16'h0000, 1'b0, 8'h74, 4'd6},   // R6
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd11},  // R11
        '{OP_MSK, 16'h0004, 1'b0, 8'h00, 4'd10},  // R10 block slot
        '{OP_REQ, 16'h4000, 1'b0, 8'h00, 4'd10},  // R10 line 14 blocked
        '{OP_REQ, 16'h0010, 1'b1, 8'h00, 4'd10},  // R10 line 4 passes
        '{OP_ACK, 16'h0000, 1'b0, 8'h0C, 4'd5},   // R5
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd10},  // R10 still blocked
        '{OP_MSK, 16'h0000, 1'b1, 8'h00, 4'd10},  // R10 latched 14 forwarded
        '{OP_ACK, 16'h0000, 1'b0, 8'h76, 4'd6},   // R6
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd11},  // R11
        '{OP_ACK, 16'h0000, 1'b0, 8'h0F, 4'd12},  // R12 nothing pending
        '{OP_REQ, 16'h0004, 1'b0, 8'h00, 4'd3},   // R3 input 2 ignored
        '{OP_REQ, 16'h8008, 1'b1, 8'h00, 4'd4},   // R4 line 15 vs 3
        '{OP_ACK, 16'h0000, 1'b0, 8'h77, 4'd4},   // R4 line 15 first
        '{OP_EOI, 16'h0000, 1'b1, 8'h00, 4'd8},   // R8 line 3 forwarded
        '{OP_ACK, 16'h0000, 1'b0, 8'h0B, 4'd4},   // R4
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd11},  // R11
        '{OP_REQ, 16'h0003, 1'b1, 8'h00, 4'd4},   // R4 lines 0 and 1
        '{OP_ACK, 16'h0000, 1'b0, 8'h08, 4'd4},   // R4 line 0 first
        '{OP_ACK, 16'h0000, 1'b0, 8'h0F, 4'd12},  // R12 int low -> spurious
        '{OP_EOI, 16'h0000, 1'b1, 8'h00, 4'd12},  // R12 line 1 survived
        '{OP_ACK, 16'h0000, 1'b0, 8'h09, 4'd5},   // R5
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd11},  // R11
        '{OP_MSK, 16'h0040, 1'b0, 8'h00, 4'd10},  // R10
        '{OP_REQ, 16'h0040, 1'b0, 8'h00, 4'd10},  // R10 line 6 blocked
        '{OP_MSK, 16'h0000, 1'b1, 8'h00, 4'd10},  // R10 forwarded
        '{OP_ACK, 16'h0000, 1'b0, 8'h0E, 4'd5},   // R5
        '{OP_EOI, 16'h0000, 1'b0, 8'h00, 4'd11}   // R11
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_in;
    logic        mask_wr;
    logic [15:0] mask_wdata;
    logic        inta;
    logic        eoi;
    logic        int_out;
    logic [7:0]  vec_out;
    logic        vec_valid;

    int n_checks = 0;
    int n_fails  = 0;

    always #(PERIOD / 2) clk = ~clk;

    pic_cascade_top uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .inta(inta), .eoi(eoi),
        .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        irq_in = '0; mask_wr = 1'b0; mask_wdata = '0; inta = 1'b0; eoi = 1'b0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1", "int_out", 16'(int_out), 16'h0);
        check("R1", "vec_valid", 16'(vec_valid), 16'h0);

        for (int r = 0; r < NROWS; r++) begin
            string tag;
            tag = $sformatf("R%0d", ROWS[r].req);
            case (ROWS[r].op)
                OP_REQ: begin
                    irq_in = irq_in | ROWS[r].arg;
                    repeat (5) @(negedge clk);
                    irq_in = irq_in & ~ROWS[r].arg;
                    repeat (3) @(negedge clk);
                end
                OP_ACK: begin
                    inta = 1'b1;
                    @(negedge clk);
                    inta = 1'b0;
                    check(tag, $sformatf("row %0d vec_valid", r), 16'(vec_valid), 16'h1);
                    check(tag, $sformatf("row %0d vec_out", r), 16'(vec_out), 16'(ROWS[r].exp_vec));
                end
                OP_EOI: begin
                    eoi = 1'b1;
                    @(negedge clk);
                    eoi = 1'b0;
                end
                default: begin
                    mask_wr = 1'b1;
                    mask_wdata = ROWS[r].arg;
                    @(negedge clk);
                    mask_wr = 1'b0;
                end
            endcase
            check(tag, $sformatf("row %0d int_out", r), 16'(int_out), 16'(ROWS[r].exp_int));
        end

        // R7 vec_valid lasts one cycle only
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        @(negedge clk);
        check("R7", "vec_valid second cycle", 16'(vec_valid), 16'h0);

        // R2 edge latency and no retrigger while held
        irq_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2", "int_out after two edges", 16'(int_out), 16'h0);
        @(negedge clk);
        check("R2", "int_out after three edges", 16'(int_out), 16'h1);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        check("R5", "line 0 vector", 16'(vec_out), 16'h08);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
        repeat (10) @(negedge clk);
        check("R2", "held line no retrigger", 16'(int_out), 16'h0);
        irq_in[0] = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset clears pending state and mask
        mask_wr = 1'b1; mask_wdata = 16'hFFFF;
        @(negedge clk);
        mask_wr = 1'b0;
        irq_in[5] = 1'b1;
        repeat (5) @(negedge clk);
        irq_in[5] = 1'b0;
        repeat (3) @(negedge clk);
        do_reset();
        check("R1", "int_out after mid reset", 16'(int_out), 16'h0);
        irq_in[6] = 1'b1;
        repeat (5) @(negedge clk);
        irq_in[6] = 1'b0;
        check("R1", "mask cleared by reset", 16'(int_out), 16'h1);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        check("R5", "line 6 vector", 16'(vec_out), 16'h0E);

        finish_run();
    end
endmodule